// File: doc/BRIEF.md
# Parallel EEPROM Write-Completion Poller

This engine runs on the host side of a parallel EEPROM. On a start strobe it loads one byte, or a run of bytes inside one page, into the memory using chip-enable, write-enable and output-enable strobes. Each byte's value comes from the host through an index/data pair. It then waits for the memory's internal programming to finish. No busy pin is used; the engine polls the address of the final byte with normal read cycles instead.

Two polling methods are available. In inverted-data mode the engine watches the top data bit: the memory returns the complement of the written bit while it is programming. In toggle mode the engine watches the next bit down, which flips on every read while programming and holds still once programming is over. A read budget limits the wait. The operation ends with either a one-cycle done pulse or a one-cycle timeout pulse. In inverted-data mode, a full-byte comparison on the final read sets a verify-error flag.

Top module: `eep_wr_poller`

## Requirements
- R1: While reset is held and after it is released, eep_ce_n, eep_oe_n and eep_we_n are high, and done, timeout and verify_err are low.
- R2: After an accepted start, byte i (i = 0 .. last_idx) is written in order. Its address is {base_addr[AW-1:PW], (base_addr[PW-1:0] + i) mod 2^PW}, so the page bits never change, and its data is wr_byte while byte_idx = i.
- R3: In each byte write, eep_ce_n falls one cycle before eep_we_n. eep_we_n then stays low for WE_CYC cycles with eep_ce_n low and eep_oe_n high.
- R4: Successive eep_we_n falling edges within one operation are WE_CYC+2 cycles apart, and never more than LOAD_WIN cycles apart.
- R5: Each poll read holds eep_ce_n and eep_oe_n low with eep_we_n high for exactly RD_CYC cycles at the address of the last byte written. eep_din is sampled in the final cycle of the read.
- R6: Every poll read is preceded by at least GAP_CYC cycles in which all three strobes are high.
- R7: With poll_mode = 0 (inverted data), the write is finished on the first read whose bit DW-1 equals bit DW-1 of the last byte written. verify_err is then 1 exactly when that read differs from the written byte in any bit.
- R8: With poll_mode = 1 (toggle), the write is finished on the first read whose bit DW-2 equals bit DW-2 of the read just before it, in the same operation. verify_err stays 0 in this mode.
- R9: If MAX_POLLS reads complete without the write finishing, timeout pulses for one cycle after the last read, done stays low, and no further read is made.
- R10: done is a one-cycle pulse in the cycle after the finishing read. A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle |
| poll_mode | input | 1 | 0 = inverted-data polling, 1 = toggle polling |
| base_addr | input | AW | Address of the first byte; upper bits select the page |
| last_idx | input | PW | Number of bytes minus one |
| byte_idx | output | PW | Index of the byte whose data is requested |
| wr_byte | input | DW | Data for the byte at byte_idx |
| eep_ce_n | output | 1 | Memory chip enable, active low |
| eep_oe_n | output | 1 | Memory output enable, active low |
| eep_we_n | output | 1 | Memory write enable, active low |
| eep_addr | output | AW | Memory address |
| eep_dout | output | DW | Data driven toward the memory |
| eep_din | input | DW | Data read from the memory |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Read budget exhausted pulse |
| verify_err | output | 1 | Final readback mismatch, valid from done until next start |

## Verification
A behavioural memory model is driven with a set of programming lengths, measured in busy reads. A zero length separates a check on the first read from a check that needs history: inverted mode must finish on read one, toggle mode on read two. Lengths just under, at and over the read budget separate finishing on the last allowed read from timing out. In toggle mode, the final busy value and the true stored bit can match or differ, which shows whether the comparison is against the previous read and not a fixed level. Page runs that start near the top of the low address field show whether the index wraps inside the page. A deliberate single-bit corruption of the stored byte separates the verify comparison from the top-bit completion test.

// File: rtl/eep_poll_pkg.sv
package eep_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WLOW  = 3'd2,
        ST_WREL  = 3'd3,
        ST_GAP   = 3'd4,
        ST_READ  = 3'd5
    } st_e;

    localparam logic MODE_INVERT = 1'b0;
    localparam logic MODE_TOGGLE = 1'b1;

endpackage

// File: rtl/eep_page_addr.sv
module eep_page_addr #(
    parameter int AW = 17,
    parameter int PW = 8
) (
    input  logic [AW-PW-1:0] page,
    input  logic [PW-1:0]    lo,
    input  logic [PW-1:0]    idx,
    output logic [AW-1:0]    addr
);
    logic [PW-1:0] low_sum;

    // Low field wraps modulo 2^PW so the page bits never move.
    always_comb begin
        low_sum = lo + idx;
        addr    = {page, low_sum};
    end
endmodule

// File: rtl/eep_poll_judge.sv
module eep_poll_judge #(
    parameter int DW = 8
) (
    input  logic          mode,
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] last,
    input  logic          prev_tog,
    input  logic          have_prev,
    output logic          finished,
    output logic          mismatch
);
    localparam int INV_BIT = DW - 1;
    localparam int TOG_BIT = DW - 2;

    always_comb begin
        if (mode == eep_poll_pkg::MODE_TOGGLE) begin
            finished = have_prev && (rd[TOG_BIT] == prev_tog);
            mismatch = 1'b0;
        end else begin
            finished = (rd[INV_BIT] == last[INV_BIT]);
            mismatch = (rd != last);
        end
    end
endmodule

// File: rtl/eep_wr_poller.sv
module eep_wr_poller #(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int PW        = 8,
    parameter int WE_CYC    = 2,
    parameter int RD_CYC    = 2,
    parameter int GAP_CYC   = 3,
    parameter int LOAD_WIN  = 8,
    parameter int MAX_POLLS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          poll_mode,
    input  logic [AW-1:0] base_addr,
    input  logic [PW-1:0] last_idx,
    output logic [PW-1:0] byte_idx,
    input  logic [DW-1:0] wr_byte,
    output logic          eep_ce_n,
    output logic          eep_oe_n,
    output logic          eep_we_n,
    output logic [AW-1:0] eep_addr,
    output logic [DW-1:0] eep_dout,
    input  logic [DW-1:0] eep_din,
    output logic          done,
    output logic          timeout,
    output logic          verify_err
);
    import eep_poll_pkg::*;

    localparam int TMAX = (WE_CYC > RD_CYC) ? ((WE_CYC > GAP_CYC) ? WE_CYC : GAP_CYC)
                                            : ((RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PCW  = $clog2(MAX_POLLS + 1);
    localparam int GW   = AW - PW;

    typedef struct packed {
        st_e             st;
        logic [TW-1:0]   tmr;
        logic [PW-1:0]   idx;
        logic [PW-1:0]   cnt;
        logic [PW-1:0]   lo;
        logic [GW-1:0]   page;
        logic            mode;
        logic [DW-1:0]   last;
        logic [PCW-1:0]  polls;
        logic            prev_tog;
        logic            have_prev;
        logic            done;
        logic            tout;
        logic            verr;
    } reg_t;

    reg_t r_q, r_d;
    logic finished, mismatch;
    logic accept;

    eep_page_addr #(.AW(AW), .PW(PW)) u_addr (
        .page (r_q.page),
        .lo   (r_q.lo),
        .idx  (r_q.idx),
        .addr (eep_addr)
    );

    eep_poll_judge #(.DW(DW)) u_judge (
        .mode      (r_q.mode),
        .rd        (eep_din),
        .last      (r_q.last),
        .prev_tog  (r_q.prev_tog),
        .have_prev (r_q.have_prev),
        .finished  (finished),
        .mismatch  (mismatch)
    );

    assign accept = (r_q.st == ST_IDLE) && start;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tout = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st        = ST_WSET;
                    r_d.page      = base_addr[AW-1:PW];
                    r_d.lo        = base_addr[PW-1:0];
                    r_d.cnt       = last_idx;
                    r_d.mode      = poll_mode;
                    r_d.idx       = '0;
                    r_d.tmr       = '0;
                    r_d.polls     = '0;
                    r_d.have_prev = 1'b0;
                    r_d.verr      = 1'b0;
                end
            end
            ST_WSET: begin
                r_d.st  = ST_WLOW;
                r_d.tmr = '0;
            end
            ST_WLOW: begin
                if (r_q.tmr == TW'(WE_CYC - 1)) begin
                    r_d.st   = ST_WREL;
                    r_d.last = wr_byte;
                    r_d.tmr  = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_WREL: begin
                r_d.tmr = '0;
                if (r_q.idx == r_q.cnt) begin
                    r_d.st = ST_GAP;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_WSET;
                end
            end
            ST_GAP: begin
                if (r_q.tmr == TW'(GAP_CYC - 1)) begin
                    r_d.st  = ST_READ;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_READ: begin
                if (r_q.tmr == TW'(RD_CYC - 1)) begin
                    r_d.tmr       = '0;
                    r_d.polls     = r_q.polls + 1'b1;
                    r_d.prev_tog  = eep_din[DW-2];
                    r_d.have_prev = 1'b1;
                    if (finished) begin
                        r_d.done = 1'b1;
                        r_d.verr = mismatch;
                        r_d.st   = ST_IDLE;
                    end else if (r_d.polls == PCW'(MAX_POLLS)) begin
                        r_d.tout = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_GAP;
                    end
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        eep_ce_n   = !((r_q.st == ST_WSET) || (r_q.st == ST_WLOW) || (r_q.st == ST_READ));
        eep_we_n   = (r_q.st != ST_WLOW);
        eep_oe_n   = (r_q.st != ST_READ);
        eep_dout   = wr_byte;
        byte_idx   = r_q.idx;
        done       = r_q.done;
        timeout    = r_q.tout;
        verify_err = r_q.verr;
    end
endmodule

// File: rtl/eep_wr_poller_chk.sv
module eep_wr_poller_chk #(
    parameter int AW        = 17,
    parameter int PW        = 8,
    parameter int GAP_CYC   = 3,
    parameter int LOAD_WIN  = 8,
    parameter int MAX_POLLS = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          accept,
    input logic [AW-1:0] base_addr,
    input logic          eep_ce_n,
    input logic          eep_oe_n,
    input logic          eep_we_n,
    input logic [AW-1:0] eep_addr,
    input logic          done,
    input logic          timeout
);
    logic [AW-PW-1:0] page_q;
    logic [15:0]      since_fall_q;
    logic             seen_fall_q;
    logic [15:0]      hi_run_q;
    logic [15:0]      rd_cnt_q;
    logic             we_prev_q, oe_prev_q;
    logic             we_fall, oe_fall;

    assign we_fall = we_prev_q && !eep_we_n;
    assign oe_fall = oe_prev_q && !eep_oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q       <= '0;
            since_fall_q <= '0;
            seen_fall_q  <= 1'b0;
            hi_run_q     <= '0;
            rd_cnt_q     <= '0;
            we_prev_q    <= 1'b1;
            oe_prev_q    <= 1'b1;
        end else begin
            we_prev_q <= eep_we_n;
            oe_prev_q <= eep_oe_n;
            if (accept) begin
                page_q      <= base_addr[AW-1:PW];
                seen_fall_q <= 1'b0;
                rd_cnt_q    <= '0;
            end else begin
                if (we_fall) seen_fall_q <= 1'b1;
                if (oe_fall) rd_cnt_q <= rd_cnt_q + 1'b1;
            end
            if (we_fall) since_fall_q <= 16'd1;
            else if (since_fall_q != 16'hFFFF) since_fall_q <= since_fall_q + 1'b1;
            if (eep_ce_n && eep_oe_n && eep_we_n) begin
                if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 1'b1;
            end else begin
                hi_run_q <= '0;
            end
        end
    end

    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_fall |-> (eep_addr[AW-1:PW] == page_q));

    p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eep_we_n |-> (eep_oe_n && !eep_ce_n));

    p_load_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && seen_fall_q) |-> (since_fall_q <= 16'(LOAD_WIN)));

    p_read_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eep_oe_n |-> (!eep_ce_n && eep_we_n));

    p_poll_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_fall |-> (hi_run_q >= 16'(GAP_CYC)));

    p_timeout_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (rd_cnt_q == 16'(MAX_POLLS)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_end_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
endmodule

bind eep_wr_poller eep_wr_poller_chk #(
    .AW(AW), .PW(PW), .GAP_CYC(GAP_CYC), .LOAD_WIN(LOAD_WIN), .MAX_POLLS(MAX_POLLS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .base_addr (base_addr),
    .eep_ce_n  (eep_ce_n),
    .eep_oe_n  (eep_oe_n),
    .eep_we_n  (eep_we_n),
    .eep_addr  (eep_addr),
    .done      (done),
    .timeout   (timeout)
);

// File: tb/eep_wr_poller_tb.sv
`timescale 1ns/1ps
module eep_wr_poller_tb;
    localparam int AW = 17, DW = 8, PW = 8;
    localparam int WE_CYC = 2, RD_CYC = 2, GAP_CYC = 3, LOAD_WIN = 8, MAXP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          poll_mode = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [PW-1:0] last_idx = '0;
    logic [PW-1:0] byte_idx;
    logic [DW-1:0] wr_byte;
    logic          eep_ce_n, eep_oe_n, eep_we_n;
    logic [AW-1:0] eep_addr;
    logic [DW-1:0] eep_dout;
    logic [DW-1:0] eep_din;
    logic          done, timeout, verify_err;

    always #2 clk = ~clk;

    eep_wr_poller #(
        .AW(AW), .DW(DW), .PW(PW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
        .GAP_CYC(GAP_CYC), .LOAD_WIN(LOAD_WIN), .MAX_POLLS(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_mode(poll_mode),
        .base_addr(base_addr), .last_idx(last_idx), .byte_idx(byte_idx),
        .wr_byte(wr_byte), .eep_ce_n(eep_ce_n), .eep_oe_n(eep_oe_n),
        .eep_we_n(eep_we_n), .eep_addr(eep_addr), .eep_dout(eep_dout),
        .eep_din(eep_din), .done(done), .timeout(timeout), .verify_err(verify_err)
    );

    int tests = 0, fails = 0, cyc = 0;
    logic [7:0] seed = 8'd0;

    function automatic logic [7:0] pat(input logic [7:0] i, input logic [7:0] s);
        return i * 8'd37 + s;
    endfunction

    assign wr_byte = pat(byte_idx, seed);

    // ---------------- memory model ----------------
    logic [7:0]    mem [256];
    logic [7:0]    lastw = 8'd0;
    int            busy_cnt = 0, busy_n = 0, reads = 0, writes = 0;
    logic          corrupt = 1'b0;
    logic [AW-PW-1:0] exp_page = '0;
    logic [PW-1:0] exp_lo = '0;
    int            order_err = 0, page_err = 0, data_err = 0;

    always_comb begin
        if (busy_cnt > 0) eep_din = {~lastw[7], 1'(((reads + 1) & 1)), 6'b0};
        else              eep_din = mem[eep_addr[7:0]] ^ {7'b0, corrupt};
    end

    always @(negedge eep_we_n) begin
        if (eep_addr[AW-1:PW] != exp_page) page_err++;
        if (eep_addr[7:0] != 8'(exp_lo + 8'(writes))) order_err++;
    end

    always @(posedge eep_we_n) begin
        if (eep_dout != pat(8'(writes), seed) || byte_idx != 8'(writes)) data_err++;
        mem[eep_addr[7:0]] = eep_dout;
        lastw    = eep_dout;
        busy_cnt = busy_n;
        writes++;
    end

    always @(posedge eep_oe_n) begin
        if (busy_cnt > 0) busy_cnt--;
        reads++;
    end

    // ---------------- protocol monitor ----------------
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
    int since_fall = 0, oe_run = 0, hi_run = 0;
    bit seen_fall = 0;
    int err3 = 0, err4 = 0, err5 = 0, err6 = 0;
    logic [AW-1:0] exp_rd_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!eep_we_n && (!eep_oe_n || eep_ce_n)) err3++;
            if (!eep_we_n && prev_we) begin
                if (prev_ce) err3++;
                if (seen_fall && (since_fall > LOAD_WIN || since_fall != WE_CYC + 2)) err4++;
                seen_fall  = 1;
                since_fall = 1;
            end else begin
                since_fall++;
            end
            if (!eep_oe_n) begin
                if (eep_ce_n || !eep_we_n || eep_addr != exp_rd_addr) err5++;
                if (prev_oe && hi_run < GAP_CYC) err6++;
                oe_run++;
            end else if (!prev_oe) begin
                if (oe_run != RD_CYC) err5++;
                oe_run = 0;
            end
            if (eep_ce_n && eep_oe_n && eep_we_n) hi_run++;
            else hi_run = 0;
        end
        prev_we = eep_we_n; prev_oe = eep_oe_n; prev_ce = eep_ce_n;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        mode;
        logic [7:0]  lidx;
        logic [16:0] base;
        logic [7:0]  busy;
        logic        corrupt;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd0,   17'h00010, 8'd0,  1'b0, 8'd5},
        '{1'b0, 8'd3,   17'h1A2F0, 8'd3,  1'b0, 8'd17},
        '{1'b0, 8'd15,  17'h05AF8, 8'd5,  1'b1, 8'd99},
        '{1'b0, 8'd1,   17'h00100, 8'd20, 1'b0, 8'd3},
        '{1'b0, 8'd2,   17'h0C840, 8'd15, 1'b0, 8'd200},
        '{1'b0, 8'd2,   17'h0C840, 8'd16, 1'b0, 8'd201},
        '{1'b1, 8'd0,   17'h03333, 8'd0,  1'b0, 8'd64},
        '{1'b1, 8'd7,   17'h10040, 8'd4,  1'b0, 8'd11},
        '{1'b1, 8'd2,   17'h02200, 8'd30, 1'b0, 8'd77},
        '{1'b1, 8'd255, 17'h1FF00, 8'd2,  1'b1, 8'd130}
    };

    task automatic predict(input vec_t v, output bit e_done, output int e_reads, output bit e_verr);
        if (v.mode == 1'b0) begin
            if (int'(v.busy) + 1 <= MAXP) begin
                e_done = 1; e_reads = int'(v.busy) + 1; e_verr = v.corrupt;
            end else begin
                e_done = 0; e_reads = MAXP; e_verr = 0;
            end
        end else begin
            logic t6;
            t6 = pat(v.lidx, v.seed)[6];
            e_done = 0; e_reads = MAXP; e_verr = 0;
            for (int k = 2; k <= MAXP; k++) begin
                logic bk, bp;
                bk = (k <= int'(v.busy)) ? 1'(k & 1) : t6;
                bp = (k - 1 <= int'(v.busy)) ? 1'((k - 1) & 1) : t6;
                if (!e_done && bk == bp) begin
                    e_done = 1; e_reads = k;
                end
            end
        end
    endtask

    task automatic setup_op(input vec_t v);
        @(negedge clk);
        poll_mode = v.mode; last_idx = v.lidx; base_addr = v.base;
        seed = v.seed; busy_n = int'(v.busy); corrupt = v.corrupt;
        exp_page = v.base[16:8]; exp_lo = v.base[7:0];
        exp_rd_addr = {v.base[16:8], 8'(v.base[7:0] + v.lidx)};
        reads = 0; writes = 0; order_err = 0; page_err = 0; data_err = 0;
        err3 = 0; err4 = 0; err5 = 0; err6 = 0; seen_fall = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_to, output bit got_verr);
        got_done = 0; got_to = 0; got_verr = 0;
        for (int i = 0; i < 8000; i++) begin
            if (done || timeout) begin
                got_done = done; got_to = timeout; got_verr = verify_err;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done && !timeout, "R10", "end pulse width one cycle", int'(done | timeout), 0);
    endtask

    initial begin
        bit gd, gt, gv, ed, ev;
        int er;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(eep_ce_n && eep_oe_n && eep_we_n, "R1", "strobes in reset", int'({eep_ce_n, eep_oe_n, eep_we_n}), 7);
        chk(!done && !timeout && !verify_err, "R1", "flags in reset", int'({done, timeout, verify_err}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(eep_ce_n && eep_oe_n && eep_we_n && !done && !timeout, "R1", "idle after reset",
            int'({eep_ce_n, eep_oe_n, eep_we_n, done, timeout}), 28);

        for (int n = 0; n < NV; n++) begin
            predict(VEC[n], ed, er, ev);
            setup_op(VEC[n]);
            wait_end(gd, gt, gv);
            if (VEC[n].mode == 1'b0)
                chk(gd == ed && gt == !ed, "R7", $sformatf("vec %0d inverted outcome done", n), int'(gd), int'(ed));
            else
                chk(gd == ed && gt == !ed, "R8", $sformatf("vec %0d toggle outcome done", n), int'(gd), int'(ed));
            chk(reads == er, ed ? "R5" : "R9", $sformatf("vec %0d read count", n), reads, er);
            if (ed)
                chk(gv == ev, VEC[n].mode ? "R8" : "R7", $sformatf("vec %0d verify_err", n), int'(gv), int'(ev));
            chk(writes == int'(VEC[n].lidx) + 1 && order_err == 0 && data_err == 0, "R2",
                $sformatf("vec %0d bytes written in order", n), writes - order_err - data_err, int'(VEC[n].lidx) + 1);
            chk(page_err == 0, "R2", $sformatf("vec %0d page bits fixed", n), page_err, 0);
            chk(err3 == 0, "R3", $sformatf("vec %0d write strobes", n), err3, 0);
            chk(err4 == 0, "R4", $sformatf("vec %0d load window", n), err4, 0);
            chk(err5 == 0, "R5", $sformatf("vec %0d read strobes", n), err5, 0);
            chk(err6 == 0, "R6", $sformatf("vec %0d idle gap", n), err6, 0);
        end

        // R10: start while busy is ignored (second start with another page)
        begin
            vec_t v;
            v = '{1'b0, 8'd1, 17'h04410, 8'd6, 1'b0, 8'd9};
            setup_op(v);
            repeat (20) @(negedge clk);
            base_addr = 17'h1BB00; last_idx = 8'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_end(gd, gt, gv);
            chk(gd && !gt, "R10", "done despite start while busy", int'(gd), 1);
            chk(reads == 7, "R10", "read count unchanged by ignored start", reads, 7);
            repeat (30) @(negedge clk);
            chk(writes == 2 && page_err == 0, "R10", "no extra writes after ignored start", writes, 2);
            chk(eep_ce_n && eep_oe_n && eep_we_n, "R10", "idle after operation",
                int'({eep_ce_n, eep_oe_n, eep_we_n}), 7);
        end

        // R9: timeout leaves done low and makes no further reads
        begin
            vec_t v;
            v = '{1'b0, 8'd0, 17'h00777, 8'd40, 1'b0, 8'd1};
            setup_op(v);
            wait_end(gd, gt, gv);
            chk(gt && !gd, "R9", "timeout pulse without done", int'(gt), 1);
            repeat (20) @(negedge clk);
            chk(reads == MAXP, "R9", "no read after timeout", reads, MAXP);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule